// File: doc/BRIEF.md
# Software Interrupt Flag Bank

A bank of byte-wide registers, each holding one interrupt flag that software raises and lowers. Every flag drives one request line into the interrupt controller, and the controller treats that line the same as a request from a peripheral. Priority assignment, arbitration and vector generation happen elsewhere.

Software reaches the bank over a 32-bit register bus. Each access carries a byte address and an access size. One register sits at each byte address, so two bus words hold the eight registers. Inside each byte there are two control bits:

- A write-only raise bit. Writing 1 to it sets the flag, and it always reads back as 0.
- The flag itself. It reads back, and writing 1 to it clears it (write-one-to-clear).

Byte, halfword and word accesses are all allowed, provided they stay inside one 32-bit word. An access that would cross a word boundary is refused with a bus error.

Top module: `sw_irq_flag_bank`

## Requirements
- R1: After reset (rst_ni low), all flags, `irq_o`, `rdata_o` and `err_o` are 0.
- R2: Bit 1 of a register byte is the raise bit. Writing 1 there sets the flag. That bit always reads as 0, and bits 7..2 always read as 0.
- R3: Bit 0 of a register byte is the flag and is the only bit that reads back. Writing 1 to it clears the flag. Writing 0 to it, or writing 0 to the raise bit, leaves the flag unchanged.
- R4: A write with both bit 1 and bit 0 set in a byte leaves the flag at 1, whatever its earlier value.
- R5: Register n sits at byte address n. That is word n/4 (`addr_i[2]`) and lane n%4, and lane k maps to bits `[31-8k -: 8]` of `wdata_i` and `rdata_o`. The access size `size_i` is coded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. A write updates exactly the bytes from `addr_i[1:0]` up to `addr_i[1:0]+bytes-1`, all on the same clock edge. Every other register is left unchanged.
- R6: An access with `size_i` = 3, or with `addr_i[1:0]` + bytes > 4, changes no register. It raises `err_o` for one cycle, starting one cycle after the request.
- R7: A read returns data on `rdata_o` one cycle after the request. Lanes that the access does not address read as 0, and a refused access returns 0. A read never changes a flag.
- R8: `irq_o[n]` equals flag n. A change caused by a write shows on `irq_o` one cycle after the clock edge that took the write, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the first register accessed |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 refused |
| wdata_i | input | 32 | Write data, lane 0 in bits 31:24 |
| rdata_o | output | 32 | Read data, registered |
| err_o | output | 1 | Bus error, registered |
| irq_o | output | N_REGS | Registered interrupt request lines |

## Verification
The hardest case to reach from the ports is a multi-byte write in which one access both raises and clears flags in neighbouring lanes. Some of those lanes also carry both bits at once, and they must land on the same edge. Reaching the word-crossing refusals at every offset is similarly awkward.

The bench sweeps every address against every size code, once as a write and once as a read. It repeats that sweep over several generated data patterns, so every lane sees every pair of raise and clear bits. After each write it reads both words back in full, so that any stray update to an unaddressed register is seen.

// File: rtl/sw_irq_pkg.sv
package sw_irq_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LANES  = BUS_W / 8;
  localparam int unsigned SET_POS  = 1;
  localparam int unsigned FLAG_POS = 0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic logic [7:0] lane_byte(input logic [BUS_W-1:0] data, input int unsigned lane);
    return data[BUS_W-1-8*lane -: 8];
  endfunction
endpackage

// File: rtl/sw_irq_decode.sv
module sw_irq_decode
  import sw_irq_pkg::*;
#(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [LANES-1:0]  lane_en_o,
  output logic [N_REGS-1:0] wr_en_o,
  output logic              err_o
);
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [OFF_W-1:0]  off;
  logic [OFF_W+1:0]  nbytes;
  logic [OFF_W+1:0]  end_pos;
  logic              bad;

  assign off     = addr_i[OFF_W-1:0];
  assign nbytes  = (OFF_W+2)'(1) << size_i;
  assign end_pos = (OFF_W+2)'(off) + nbytes;
  assign bad     = (acc_size_e'(size_i) == SZ_RSVD) || (end_pos > (OFF_W+2)'(LANES));
  assign err_o   = req_i && bad;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_en_o[b] = req_i && !bad &&
                          ((OFF_W+2)'(b) >= (OFF_W+2)'(off)) &&
                          ((OFF_W+2)'(b) <  end_pos);
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    assign wr_en_o[i] = we_i && lane_en_o[i % LANES] &&
                        (addr_i[ADDR_W-1:OFF_W] == (ADDR_W-OFF_W)'(i / LANES));
  end
endmodule

// File: rtl/sw_irq_flag_cell.sv
module sw_irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic raise_i,
  input  logic clear_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
    end else if (wr_en_i) begin
      // raise dominates a simultaneous clear
      if (raise_i)      flag_o <= 1'b1;
      else if (clear_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sw_irq_rsp.sv
module sw_irq_rsp
  import sw_irq_pkg::*;
#(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [N_REGS-1:0] flags_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              err_o
);
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [BUS_W-1:0] rdata_d;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic flag_sel;
    assign flag_sel = flags_i[{addr_i[ADDR_W-1:OFF_W], OFF_W'(b)}];
    always_comb begin
      rdata_d[BUS_W-1-8*b -: 8] = 8'h00;
      if (rd_i && lane_en_i[b]) rdata_d[BUS_W-1-8*b-(7-FLAG_POS)] = flag_sel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      err_o   <= err_i;
    end
  end
endmodule

// File: rtl/sw_irq_flag_bank.sv
module sw_irq_flag_bank
  import sw_irq_pkg::*;
#(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              err_o,
  output logic [N_REGS-1:0] irq_o
);
  logic [LANES-1:0]  lane_en;
  logic [N_REGS-1:0] wr_en;
  logic [N_REGS-1:0] flags;
  logic              acc_err;

  sw_irq_decode #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .lane_en_o (lane_en),
    .wr_en_o   (wr_en),
    .err_o     (acc_err)
  );

  for (genvar i = 0; i < N_REGS; i++) begin : g_cell
    logic [7:0] wbyte;
    assign wbyte = lane_byte(wdata_i, i % LANES);
    sw_irq_flag_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en[i]),
      .raise_i (wbyte[SET_POS]),
      .clear_i (wbyte[FLAG_POS]),
      .flag_o  (flags[i])
    );
  end

  sw_irq_rsp #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (req_i && !we_i),
    .err_i     (acc_err),
    .addr_i    (addr_i),
    .lane_en_i (lane_en),
    .flags_i   (flags),
    .rdata_o   (rdata_o),
    .err_o     (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= flags;
  end
endmodule

// File: rtl/sw_irq_flag_bank_chk.sv
module sw_irq_flag_bank_chk
  import sw_irq_pkg::*;
#(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned ADDR_W = $clog2(N_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              err_o,
  input logic [N_REGS-1:0] irq_o
);
  function automatic logic raise_at(input logic [BUS_W-1:0] d, input logic [ADDR_W-1:0] a);
    logic [7:0] by;
    by = lane_byte(d, a % LANES);
    return by[SET_POS];
  endfunction

  // R8: request lines move only two edges after a write request
  a_r8_irq_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != $past(irq_o)) |-> $past(req_i && we_i, 2));

  // R6: refused write leaves request lines alone
  a_r6_err_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(we_i)) |=> $stable(irq_o));

  // R6: error only in response to a request
  a_r6_err_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));

  // R7: refused access returns zero data
  a_r7_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  // R2: only flag positions ever read as one
  a_r2_only_flag_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & 32'hFEFE_FEFE) == '0);

  // R4: byte write with raise bit ends with the flag set
  a_r4_raise_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == 2'd0 && raise_at(wdata_i, addr_i))
      |-> ##2 irq_o[$past(addr_i, 2)]);
endmodule

bind sw_irq_flag_bank sw_irq_flag_bank_chk #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sw_irq_flag_bank_tb.sv
module sw_irq_flag_bank_tb;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic [7:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model = '0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #5 clk_i = ~clk_i;

  sw_irq_flag_bank #(.N_REGS(N)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit crosses(input logic [2:0] a, input logic [1:0] s);
    return (s == 2'd3) || (int'(a[1:0]) + (1 << s) > 4);
  endfunction

  task automatic access(input logic w, input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    logic bad;
    logic [31:0] exp_rd;
    logic [7:0] prev;
    bad = crosses(a, s);
    prev = model;
    exp_rd = '0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; size_i = s; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int b = 0; b < 4; b++) begin
      if (!bad && b >= int'(a[1:0]) && b < int'(a[1:0]) + (1 << s)) begin
        int idx;
        logic [7:0] by;
        idx = int'(a[2]) * 4 + b;
        by = d[31-8*b -: 8];
        if (!w) exp_rd[31-8*b -: 8] = {7'b0, prev[idx]};
        else if (by[1]) model[idx] = 1'b1;   // R4 raise wins
        else if (by[0]) model[idx] = 1'b0;   // R3
      end
    end
    check("R6 err", {31'b0, err_o}, {31'b0, bad});
    check("R7 rdata", rdata_o, exp_rd);
    check("R8 irq not early", {24'b0, irq_o}, {24'b0, prev});
    @(negedge clk_i);
    check("R5 irq after write", {24'b0, irq_o}, {24'b0, model});
  endtask

  task automatic read_all();
    for (int w = 0; w < 2; w++) begin
      @(negedge clk_i);
      req_i = 1'b1; we_i = 1'b0; addr_i = 3'(w * 4); size_i = 2'd2;
      @(negedge clk_i);
      req_i = 1'b0;
      check("R7 word readback", rdata_o,
            {7'b0, model[w*4], 7'b0, model[w*4+1], 7'b0, model[w*4+2], 7'b0, model[w*4+3]});
    end
  endtask

  initial begin
    fork
      begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        #23 rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 irq reset", {24'b0, irq_o}, 32'h0);
        check("R1 err reset", {31'b0, err_o}, 32'h0);
        check("R1 rdata reset", rdata_o, 32'h0);
        read_all();
        // directed: raise, clear, raise+clear, zero writes
        access(1'b1, 3'd5, 2'd0, 32'h0002_0000);
        access(1'b1, 3'd5, 2'd0, 32'h0000_0000);        // R3 zero no effect
        access(1'b1, 3'd5, 2'd0, 32'h0001_0000);        // R3 clear
        access(1'b1, 3'd5, 2'd0, 32'h0003_0000);        // R4 both, was clear
        access(1'b1, 3'd5, 2'd0, 32'h0003_0000);        // R4 both, was set
        access(1'b1, 3'd3, 2'd1, 32'hFFFF_FFFF);        // R6 crossing
        access(1'b1, 3'd0, 2'd3, 32'hFFFF_FFFF);        // R6 reserved size
        access(1'b1, 3'd1, 2'd1, 32'h0002_0200);        // R5 halfword at offset 1
        access(1'b1, 3'd4, 2'd2, 32'h0203_0102);        // R5 word mixed
        read_all();
        // sweep
        for (int rep = 0; rep < 6; rep++) begin
          for (int a = 0; a < 8; a++) begin
            for (int s = 0; s < 4; s++) begin
              for (int w = 0; w < 2; w++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                access(w[0], a[2:0], s[1:0], lfsr & 32'h0303_0303);
              end
            end
            read_all();
          end
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule